// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the memory-mapped side of an SPI host controller. Software reaches it through 32-bit, word-aligned register reads and writes. Bytes written to the transmit data register are queued in a small transmit FIFO. A transfer engine hands the queued bytes one at a time to a byte-exchange port, which stands in for the serial shifter. The byte that comes back from each exchange is queued in a receive FIFO, and software pops it by reading the receive data register.

The two data registers do not read back data in the usual way. Their bit 31 is a status flag. Two pending bits compare the FIFO fill levels against programmable watermarks, and these bits, masked by an enable register, drive one level interrupt. The block also drives a parameterised set of chip-select outputs from a default mask and a mode register. Configuration writes with values out of range are dropped without any report. The divider, clock-mode and delay registers are kept only as storage.

Top module: `spi_host_frontend`

## Requirements
- R1: After reset, the divider register (offset 0x00) reads 0x3, delay0 (0x28) reads 0x1001, delay1 (0x2C) reads 0x1, and the chip-select default register (0x14) reads one set bit per chip select. All other registers read 0. Both FIFOs are empty, every chip-select output is high and the interrupt is low.
- R2: A read of transmit data (0x48) returns 0x80000000 while the transmit FIFO holds 8 bytes, and 0 otherwise.
- R3: A read of receive data (0x4C) returns 0x80000000 when the receive FIFO is empty. Otherwise it removes the oldest byte and returns it in bits 7:0, with all other bits zero.
- R4: A write to transmit data queues bits 7:0 only if the transmit FIFO is not full, and drops the write otherwise. Queued bytes leave through the exchange port in write order, one transfer outstanding at a time. The data is held stable while valid is high and ready is low.
- R5: A returned byte is queued in the receive FIFO only when that FIFO is not full and bit 3 of the frame format register (0x40) is clear. With bit 3 set, every returned byte is dropped.
- R6: Pending register (0x74) bit 0 is 1 while the transmit fill level is strictly below the transmit watermark (0x50). Bit 1 is 1 while the receive fill level is strictly above the receive watermark (0x54).
- R7: The interrupt output is high exactly when the pending bits ANDed with the enable register (0x70) are nonzero.
- R8: A write leaves its register unchanged if it is a watermark of 8 or more, a chip-select mode (0x18) above 3, a chip-select id (0x10) not below the number of chip selects, or a chip-select default not below 2 to the power of the number of chip selects.
- R9: Writes to receive data, to the pending register, to unmapped offsets inside the window and to offsets at 0x78 and above have no effect. Unmapped offsets and offsets beyond the window read 0.
- R10: On an accepted write to chip-select id or chip-select mode, each chip-select output whose bit is set in the default register goes high if the resulting mode is 0, and low otherwise. Outputs whose default bit is clear keep their level.
- R11: Every read returns its data with rsp_valid exactly one cycle after the request, and writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request, accepted every cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| xfer_valid | output | 1 | A byte is offered to the exchange port |
| xfer_data | output | 8 | Byte being offered |
| xfer_ready | input | 1 | The exchange port takes the byte |
| ret_valid | input | 1 | Single-cycle pulse with the returned byte |
| ret_data | input | 8 | Returned byte |
| cs_out | output | NUM_CS | Chip-select levels |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due on the first clock edge after the request. The bench drives a request at a falling edge, and a monitor compares the response at the following falling edge against a queue of expected words that the driver task filled. Writes take effect at that same edge, so the chip-select levels and the interrupt are checked at the falling edge that ends the write task. The FIFO and exchange effects need several cycles (one to launch, then the peer's ready and return delay). The bench therefore waits a fixed number of idle cycles before it reads the FIFOs back or compares the log of exchanged bytes.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int OFF_DIV     = 'h00;
  localparam int OFF_SCKMODE = 'h04;
  localparam int OFF_CSID    = 'h10;
  localparam int OFF_CSDEF   = 'h14;
  localparam int OFF_CSMODE  = 'h18;
  localparam int OFF_DLY0    = 'h28;
  localparam int OFF_DLY1    = 'h2C;
  localparam int OFF_FMT     = 'h40;
  localparam int OFF_TXD     = 'h48;
  localparam int OFF_RXD     = 'h4C;
  localparam int OFF_TXMARK  = 'h50;
  localparam int OFF_RXMARK  = 'h54;
  localparam int OFF_IE      = 'h70;
  localparam int OFF_IP      = 'h74;
  localparam int WINDOW_END  = 'h78;

  localparam logic [31:0] RST_DIV  = 32'h3;
  localparam logic [31:0] RST_DLY0 = 32'h1001;
  localparam logic [31:0] RST_DLY1 = 32'h1;
  localparam logic [31:0] STATUS_FLAG = 32'h8000_0000;
  localparam int FMT_DROP_BIT = 3;

  typedef enum logic [1:0] {XF_IDLE, XF_SEND, XF_WAIT} xfer_state_e;

  function automatic logic tx_below_mark(input int fill, input int mark);
    return fill < mark;
  endfunction

  function automatic logic rx_above_mark(input int fill, input int mark);
    return fill > mark;
  endfunction

  function automatic logic [31:0] flag_or_zero(input logic flag);
    return flag ? STATUS_FLAG : 32'h0;
  endfunction

endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full  = (int'(count) == DEPTH);
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr <= next_ptr(wr_ptr);
      end
      if (pop) rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/spi_fe_xfer.sv
module spi_fe_xfer
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_empty,
  input  logic [7:0] tx_head,
  output logic       tx_pop,
  output logic       xfer_valid,
  output logic [7:0] xfer_data,
  input  logic       xfer_ready,
  input  logic       ret_valid,
  input  logic [7:0] ret_data,
  input  logic       rx_full,
  input  logic       drop_rx,
  output logic       rx_push,
  output logic [7:0] rx_din
);
  xfer_state_e state_q;
  logic [7:0]  byte_q;
  logic        launch, accept, done;

  assign launch = (state_q == XF_IDLE) && !tx_empty;
  assign accept = (state_q == XF_SEND) && xfer_ready;
  assign done   = (state_q == XF_WAIT) && ret_valid;

  assign tx_pop     = launch;
  assign xfer_valid = (state_q == XF_SEND);
  assign xfer_data  = byte_q;
  assign rx_push    = done && !rx_full && !drop_rx;
  assign rx_din     = ret_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      byte_q  <= '0;
    end else begin
      if (launch) begin
        byte_q  <= tx_head;
        state_q <= XF_SEND;
      end else if (accept) begin
        state_q <= XF_WAIT;
      end else if (done) begin
        state_q <= XF_IDLE;
      end
    end
  end

  p_hold_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_data)));
  p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !xfer_valid);
  p_drop_when_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_rx |-> !rx_push);

endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs
  import spi_fe_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int MARK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              tx_full,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_empty,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [7:0]        rx_head,
  output logic              tx_push,
  output logic [7:0]        tx_din,
  output logic              rx_pop,
  output logic              drop_rx,
  output logic [NUM_CS-1:0] cs_out,
  output logic              irq
);
  logic [31:0]       div_q, sckmode_q, dly0_q, dly1_q, fmt_q, ie_q, csid_q;
  logic [NUM_CS-1:0] csdef_q;
  logic [1:0]        csmode_q;
  logic [MARK_W-1:0] txmark_q, rxmark_q;

  int          off;
  logic        in_win, wr, rd;
  logic        csid_ok, csdef_ok, csmode_ok, mark_ok;
  logic        csid_wr_ok, csmode_wr_ok, cs_refresh;
  logic [1:0]  next_mode;
  logic [1:0]  pend;
  logic [31:0] rd_data;

  assign off    = int'(req_addr);
  assign in_win = off < WINDOW_END;
  assign wr     = req_valid && req_write && in_win;
  assign rd     = req_valid && !req_write;

  assign csid_ok   = req_wdata < 32'(NUM_CS);
  assign csdef_ok  = (req_wdata >> NUM_CS) == 32'h0;
  assign csmode_ok = req_wdata <= 32'd3;
  assign mark_ok   = req_wdata < 32'(DEPTH);

  assign csid_wr_ok   = wr && (off == OFF_CSID) && csid_ok;
  assign csmode_wr_ok = wr && (off == OFF_CSMODE) && csmode_ok;
  assign cs_refresh   = csid_wr_ok || csmode_wr_ok;
  assign next_mode    = csmode_wr_ok ? req_wdata[1:0] : csmode_q;

  assign tx_push = wr && (off == OFF_TXD) && !tx_full;
  assign tx_din  = req_wdata[7:0];
  assign rx_pop  = rd && (off == OFF_RXD) && !rx_empty;
  assign drop_rx = fmt_q[FMT_DROP_BIT];

  assign pend[0] = tx_below_mark(int'(tx_count), int'(txmark_q));
  assign pend[1] = rx_above_mark(int'(rx_count), int'(rxmark_q));
  assign irq     = |(pend & ie_q[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= RST_DIV;
      sckmode_q <= '0;
      dly0_q    <= RST_DLY0;
      dly1_q    <= RST_DLY1;
      fmt_q     <= '0;
      ie_q      <= '0;
      csid_q    <= '0;
      csdef_q   <= '1;
      csmode_q  <= '0;
      txmark_q  <= '0;
      rxmark_q  <= '0;
    end else if (wr) begin
      case (off)
        OFF_DIV:     div_q     <= req_wdata;
        OFF_SCKMODE: sckmode_q <= req_wdata;
        OFF_DLY0:    dly0_q    <= req_wdata;
        OFF_DLY1:    dly1_q    <= req_wdata;
        OFF_FMT:     fmt_q     <= req_wdata;
        OFF_IE:      ie_q      <= req_wdata;
        OFF_CSID:    if (csid_ok)   csid_q   <= req_wdata;
        OFF_CSDEF:   if (csdef_ok)  csdef_q  <= req_wdata[NUM_CS-1:0];
        OFF_CSMODE:  if (csmode_ok) csmode_q <= req_wdata[1:0];
        OFF_TXMARK:  if (mark_ok)   txmark_q <= req_wdata[MARK_W-1:0];
        OFF_RXMARK:  if (mark_ok)   rxmark_q <= req_wdata[MARK_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (!rst_n)                        cs_out[i] <= 1'b1;
      else if (cs_refresh && csdef_q[i]) cs_out[i] <= (next_mode == 2'd0);
    end
  end

  always_comb begin
    case (off)
      OFF_DIV:     rd_data = div_q;
      OFF_SCKMODE: rd_data = sckmode_q;
      OFF_CSID:    rd_data = csid_q;
      OFF_CSDEF:   rd_data = 32'(csdef_q);
      OFF_CSMODE:  rd_data = 32'(csmode_q);
      OFF_DLY0:    rd_data = dly0_q;
      OFF_DLY1:    rd_data = dly1_q;
      OFF_FMT:     rd_data = fmt_q;
      OFF_TXD:     rd_data = flag_or_zero(tx_full);
      OFF_RXD:     rd_data = rx_empty ? STATUS_FLAG : {24'h0, rx_head};
      OFF_TXMARK:  rd_data = 32'(txmark_q);
      OFF_RXMARK:  rd_data = 32'(rxmark_q);
      OFF_IE:      rd_data = ie_q;
      OFF_IP:      rd_data = {30'h0, pend};
      default:     rd_data = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_data;
    end
  end

  p_mark_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_TXMARK && !mark_ok) |=> $stable(txmark_q));
  p_cs_deassert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csmode_wr_ok && req_wdata[1:0] != 2'd0) |=> ((cs_out & $past(csdef_q)) == '0));
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q[1:0] != 2'b00));
  p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  p_no_write_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

endmodule

// File: rtl/spi_host_frontend.sv
module spi_host_frontend #(
  parameter int NUM_CS     = 1,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              xfer_valid,
  output logic [7:0]        xfer_data,
  input  logic              xfer_ready,
  input  logic              ret_valid,
  input  logic [7:0]        ret_data,
  output logic [NUM_CS-1:0] cs_out,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_din, tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_din, rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             drop_rx;

  spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din), .pop(tx_pop),
    .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty));

  spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

  spi_fe_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_pop(tx_pop), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
    .xfer_ready(xfer_ready), .ret_valid(ret_valid), .ret_data(ret_data),
    .rx_full(rx_full), .drop_rx(drop_rx), .rx_push(rx_push), .rx_din(rx_din));

  spi_fe_regs #(.NUM_CS(NUM_CS), .DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tx_full(tx_full), .tx_count(tx_count),
    .rx_empty(rx_empty), .rx_count(rx_count), .rx_head(rx_head),
    .tx_push(tx_push), .tx_din(tx_din), .rx_pop(rx_pop), .drop_rx(drop_rx),
    .cs_out(cs_out), .irq(irq));

endmodule

// File: tb/tb_spi_host_frontend.sv
module tb_spi_host_frontend;
  localparam int NCS = 2;
  localparam logic [31:0] FLAG = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [7:0]  xfer_data;
  logic        ret_valid = 1'b0;
  logic [7:0]  ret_data = '0;
  logic [NCS-1:0] cs_out;
  logic        irq;

  int checks = 0, errors = 0;
  bit hold = 1'b0;
  logic [7:0] sent_q[$];

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  spi_host_frontend #(.NUM_CS(NCS), .FIFO_DEPTH(8), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
    .xfer_ready(xfer_ready), .ret_valid(ret_valid), .ret_data(ret_data),
    .cs_out(cs_out), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int addr, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(addr);
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: a response is due one edge after its request (R11)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk("R11 unexpected response", rsp_rdata, 32'hx);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, rsp_rdata, e.exp);
      end
    end
  end

  // exchange peer: ready after one cycle, returns byte ^ 0xA5 two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_valid && !hold) begin
        logic [7:0] b;
        b = xfer_data;
        sent_q.push_back(b);
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0;
        idle(2);
        ret_valid = 1'b1; ret_data = b ^ 8'hA5;
        @(negedge clk);
        ret_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 cs_out", 32'(cs_out), 32'h3);
    chk("R1 irq", 32'(irq), 32'h0);
    bus_rd('h00, 32'h3, "R1 divider");
    bus_rd('h28, 32'h1001, "R1 delay0");
    bus_rd('h2C, 32'h1, "R1 delay1");
    bus_rd('h14, 32'h3, "R1 csdef");
    bus_rd('h40, 32'h0, "R1 fmt");
    bus_rd('h74, 32'h0, "R1 pending");
    bus_rd('h48, 32'h0, "R2 tx not full");
    bus_rd('h4C, FLAG, "R3 rx empty");

    // R10 chip selects
    bus_wr('h18, 32'h2);
    chk("R10 mode 2 drives low", 32'(cs_out), 32'h0);
    bus_wr('h14, 32'h1);
    bus_wr('h18, 32'h0);
    chk("R10 only default bits follow", 32'(cs_out), 32'h1);
    bus_wr('h18, 32'h3);
    bus_wr('h14, 32'h2);
    bus_wr('h10, 32'h1);
    chk("R10 id write refreshes", 32'(cs_out), 32'h0);

    // R8 rejected values
    bus_wr('h14, 32'h4);
    bus_rd('h14, 32'h2, "R8 csdef kept");
    bus_wr('h18, 32'h5);
    bus_rd('h18, 32'h3, "R8 csmode kept");
    bus_wr('h10, 32'h2);
    bus_rd('h10, 32'h1, "R8 csid kept");
    bus_wr('h50, 32'h3);
    bus_wr('h50, 32'h8);
    bus_rd('h50, 32'h3, "R8 txmark kept");
    bus_wr('h50, 32'h0);

    // R9 ignored writes
    bus_wr('h08, 32'hFFFF);
    bus_rd('h08, 32'h0, "R9 reserved reads zero");
    bus_wr('h74, 32'h3);
    bus_rd('h74, 32'h0, "R9 pending write ignored");
    bus_wr('h4C, 32'h55);
    bus_rd('h4C, FLAG, "R9 rxdata write ignored");
    bus_wr('h100, 32'h1234);
    bus_rd('h100, 32'h0, "R9 beyond window");
    bus_rd('h00, 32'h3, "R9 divider untouched");

    // R6/R7 transmit watermark
    bus_wr('h50, 32'h4);
    bus_rd('h74, 32'h1, "R6 tx below mark");
    chk("R7 irq masked", 32'(irq), 32'h0);
    bus_wr('h70, 32'h1);
    chk("R7 irq on tx mark", 32'(irq), 32'h1);
    bus_wr('h50, 32'h0);
    chk("R7 irq drops", 32'(irq), 32'h0);

    // R2/R4/R5 fill with the peer stalled
    hold = 1'b1;
    bus_wr('h54, 32'h2);
    for (int i = 0; i < 9; i++) bus_wr('h48, 32'h10 + 32'(i));
    idle(2);
    bus_rd('h48, FLAG, "R2 tx full");
    bus_wr('h48, 32'hEE);
    hold = 1'b0;
    idle(120);
    chk("R4 sent count", 32'(sent_q.size()), 32'd9);
    for (int i = 0; i < 9; i++)
      if (i < sent_q.size()) chk("R4 order", 32'(sent_q[i]), 32'h10 + 32'(i));
    bus_rd('h48, 32'h0, "R2 tx drained");
    bus_rd('h74, 32'h2, "R6 rx above mark");
    bus_wr('h70, 32'h2);
    chk("R7 irq on rx mark", 32'(irq), 32'h1);
    for (int i = 0; i < 8; i++)
      bus_rd('h4C, 32'((8'h10 + 8'(i)) ^ 8'hA5), "R3 R5 rx pop");
    bus_rd('h4C, FLAG, "R5 ninth byte dropped when full");
    chk("R7 irq clears", 32'(irq), 32'h0);

    // R5 direction bit drops returns
    bus_wr('h40, 32'h8);
    bus_wr('h48, 32'h31);
    bus_wr('h48, 32'h32);
    idle(30);
    chk("R4 sent with drop", 32'(sent_q.size()), 32'd11);
    bus_rd('h4C, FLAG, "R5 dropped with dir bit");
    bus_wr('h40, 32'h0);
    bus_wr('h48, 32'h40);
    idle(20);
    bus_rd('h4C, 32'(8'h40 ^ 8'hA5), "R5 capture restored");

    idle(4);
    chk("R11 all responses seen", 32'(sb_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule